// File: doc/BRIEF.md
# Video Row Streamer

This block holds a small word-addressed array reachable through two independent paths. The random-access path performs ordinary word reads and writes. It also carries a transfer command. That command copies one complete row of the array in a single cycle into an internal line buffer. The second path is a read-only serial stream. On every clock in which the step enable is high, it moves on to the next word of the captured row, in ascending column order. One row is meant to hold one full horizontal line of pixels for a display.

Once a row has been captured, the random-access path is free again. Word reads and writes continue while the stream is running, and they never disturb the captured line. A transfer may name a start column so that streaming begins part-way along the row. After the last column the stream wraps around to column 0 and keeps going until the next transfer. Two parameter-selected implementations of the line buffer are provided: a rotating ring and an indexed buffer with a column pointer. Both show the same behaviour at the ports.

Top module: `video_row_streamer`

## Requirements
- R1: After reset the serial output is zero, and it stays zero while stepping until the first transfer.
- R2: A random-access read returns the word at the row/column address sampled at a clock edge, presented one cycle later. A word written at one edge is returned by a read of the same address at a later edge.
- R3: A read and a write to the same address at the same edge return the contents that the address held before that write.
- R4: In the cycle after a transfer edge, the serial output shows the captured row's word at the start column. With the start tap enabled, the start column is the random-access column address.
- R5: Each edge with step high and no transfer advances the serial output to the next higher column of the captured row.
- R6: After column COLS-1 the serial output continues at column 0 of the same captured row.
- R7: At an edge with step low and no transfer, the serial output holds its value.
- R8: Writes to the array after a transfer leave the words already captured in the line buffer unchanged.
- R9: A transfer and a step at the same edge act as a transfer alone: the output shows the start column, not the one after it.
- R10: A transfer and a write to the same row at the same edge capture the row as it was before that write.
- R11: Random-access reads return correct data while the serial stream is stepping or holding.
- R12: With the start tap disabled, every transfer begins streaming at column 0, whatever the column address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every register uses the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the serial state |
| ra_row | input | clog2(ROWS) | Row address for read, write and transfer |
| ra_col | input | clog2(COLS) | Column address for read/write; start column for a transfer |
| ra_wdata | input | DATA_W | Write data |
| ra_we | input | 1 | Write enable for one word |
| ra_xfer | input | 1 | Capture the addressed row into the line buffer |
| ra_rdata | output | DATA_W | Registered read data, one cycle latency |
| ser_step | input | 1 | Advance the serial stream by one word |
| ser_data | output | DATA_W | Current serial word |

## Verification
If a capture takes the wrong row, or the start tap is misapplied, the very first serial word after the transfer is wrong. If the column sequence is broken, the fault shows at the first step that skips, repeats or fails to wrap. That can take up to COLS steps, so the stimulus runs full laps of a row. A line buffer that is coupled to later array writes looks correct until it reaches the column that was rewritten. For that reason, rewrites are made across a whole row while that row streams for a complete lap. Random-port ordering faults, such as read-first versus write-first, show in the single read that coincides with a write.

// File: rtl/vrs_pkg.sv
package vrs_pkg;

   // Line-buffer implementation choice.
   typedef enum logic {
      VRS_ROTATE  = 1'b0,
      VRS_POINTER = 1'b1
   } vrs_impl_e;

   // Index width that stays legal for tiny counts.
   function automatic int unsigned idx_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/vrs_array.sv
module vrs_array #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ROWS   = 8,
   parameter int unsigned COLS   = 16
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 we,
   input  logic [vrs_pkg::idx_w(ROWS)-1:0]      row,
   input  logic [vrs_pkg::idx_w(COLS)-1:0]      col,
   input  logic [DATA_W-1:0]                    wdata,
   output logic [DATA_W-1:0]                    rdata,
   output logic [COLS*DATA_W-1:0]               line
);
   localparam int unsigned LINE_W = COLS * DATA_W;

   // One storage entry per row so a full line can be read at once.
   logic [LINE_W-1:0] mem [ROWS];

   // Whole-row read for the transfer path (pre-write contents at the edge).
   assign line = mem[row];

   always_ff @(posedge clk) begin
      rdata <= mem[row][col*DATA_W +: DATA_W];
      if (we) begin
         mem[row][col*DATA_W +: DATA_W] <= wdata;
      end
   end

   // R2
   wr_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(we) && row == $past(row) && col == $past(col))
      |=> rdata == $past(wdata, 2));

endmodule

// File: rtl/vrs_serial.sv
module vrs_serial #(
   parameter int unsigned        DATA_W    = 8,
   parameter int unsigned        COLS      = 16,
   parameter vrs_pkg::vrs_impl_e IMPL      = vrs_pkg::VRS_ROTATE,
   parameter bit                 START_TAP = 1'b1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            load,
   input  logic                            step,
   input  logic [vrs_pkg::idx_w(COLS)-1:0] start_col,
   input  logic [COLS*DATA_W-1:0]          line,
   output logic [DATA_W-1:0]               sdata
);
   localparam int unsigned LINE_W = COLS * DATA_W;
   localparam int unsigned COL_W  = vrs_pkg::idx_w(COLS);
   localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

   logic [COL_W-1:0] first_col;

   generate
      if (START_TAP) begin : g_tap
         assign first_col = start_col;
      end else begin : g_no_tap
         logic unused_start;
         assign unused_start = ^start_col;
         assign first_col    = '0;
      end
   endgenerate

   generate
      if (IMPL == vrs_pkg::VRS_ROTATE) begin : g_rotate
         logic [LINE_W-1:0]   ring_q;
         logic [2*LINE_W-1:0] twice;

         // Pre-rotate so the start column sits in the output slot.
         assign twice = {line, line} >> (first_col * DATA_W);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ring_q <= '0;
            end else if (load) begin
               ring_q <= twice[LINE_W-1:0];
            end else if (step) begin
               ring_q <= {ring_q[DATA_W-1:0], ring_q[LINE_W-1:DATA_W]};
            end
         end

         assign sdata = ring_q[DATA_W-1:0];

         // R6
         ring_keeps_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (step && !load) |=> $countones(ring_q) == $past($countones(ring_q)));

      end else begin : g_pointer
         logic [LINE_W-1:0] buf_q;
         logic [COL_W-1:0]  ptr_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               buf_q <= '0;
               ptr_q <= '0;
            end else if (load) begin
               buf_q <= line;
               ptr_q <= first_col;
            end else if (step) begin
               ptr_q <= (ptr_q == LAST_COL) ? '0 : ptr_q + 1'b1;
            end
         end

         assign sdata = buf_q[ptr_q*DATA_W +: DATA_W];

         // R5
         ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (step && !load && ptr_q != LAST_COL) |=> ptr_q == $past(ptr_q) + 1'b1);

         // R6
         ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (step && !load && ptr_q == LAST_COL) |=> ptr_q == '0);

         // R8
         buf_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !load |=> $stable(buf_q));
      end
   endgenerate

   // R7
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !step) |=> $stable(sdata));

endmodule

// File: rtl/video_row_streamer.sv
module video_row_streamer #(
   parameter int unsigned        DATA_W    = 8,
   parameter int unsigned        ROWS      = 8,
   parameter int unsigned        COLS      = 16,
   parameter vrs_pkg::vrs_impl_e IMPL      = vrs_pkg::VRS_ROTATE,
   parameter bit                 START_TAP = 1'b1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [vrs_pkg::idx_w(ROWS)-1:0] ra_row,
   input  logic [vrs_pkg::idx_w(COLS)-1:0] ra_col,
   input  logic [DATA_W-1:0]               ra_wdata,
   input  logic                            ra_we,
   input  logic                            ra_xfer,
   output logic [DATA_W-1:0]               ra_rdata,
   input  logic                            ser_step,
   output logic [DATA_W-1:0]               ser_data
);
   localparam int unsigned LINE_W = COLS * DATA_W;
   localparam int unsigned COL_W  = vrs_pkg::idx_w(COLS);

   // Elaboration-time parameter checks.
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("video_row_streamer: DATA_W must be at least 1");
      end
      if (ROWS < 2 || (ROWS & (ROWS - 1)) != 0) begin : g_bad_rows
         $error("video_row_streamer: ROWS must be a power of two >= 2");
      end
      if (COLS < 2 || (COLS & (COLS - 1)) != 0) begin : g_bad_cols
         $error("video_row_streamer: COLS must be a power of two >= 2");
      end
   endgenerate

   logic [LINE_W-1:0] row_line;
   logic [COL_W-1:0]  head_col;
   logic [DATA_W-1:0] head_word;

   vrs_array #(
      .DATA_W (DATA_W),
      .ROWS   (ROWS),
      .COLS   (COLS)
   ) u_array (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (ra_we),
      .row   (ra_row),
      .col   (ra_col),
      .wdata (ra_wdata),
      .rdata (ra_rdata),
      .line  (row_line)
   );

   vrs_serial #(
      .DATA_W    (DATA_W),
      .COLS      (COLS),
      .IMPL      (IMPL),
      .START_TAP (START_TAP)
   ) u_serial (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (ra_xfer),
      .step      (ser_step),
      .start_col (ra_col),
      .line      (row_line),
      .sdata     (ser_data)
   );

   // Word expected at the serial output after a transfer (checker only).
   assign head_col  = START_TAP ? ra_col : '0;
   assign head_word = row_line[head_col*DATA_W +: DATA_W];

   // R4
   xfer_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ra_xfer |=> ser_data == $past(head_word));

endmodule

// File: tb/video_row_streamer_test.sv
module video_row_streamer_test;
   localparam int unsigned DW   = 8;
   localparam int unsigned NR   = 8;
   localparam int unsigned NC   = 16;
   localparam int unsigned RW   = 3;
   localparam int unsigned CW   = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [RW-1:0] ra_row = '0;
   logic [CW-1:0] ra_col = '0;
   logic [DW-1:0] ra_wdata = '0;
   logic          ra_we = 1'b0;
   logic          ra_xfer = 1'b0;
   logic          ser_step = 1'b0;
   logic [DW-1:0] rd_a, rd_b, sd_a, sd_b;

   always #10 clk = ~clk;

   video_row_streamer #(.DATA_W(DW), .ROWS(NR), .COLS(NC),
      .IMPL(vrs_pkg::VRS_ROTATE), .START_TAP(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .ra_row(ra_row), .ra_col(ra_col),
      .ra_wdata(ra_wdata), .ra_we(ra_we), .ra_xfer(ra_xfer),
      .ra_rdata(rd_a), .ser_step(ser_step), .ser_data(sd_a));

   video_row_streamer #(.DATA_W(DW), .ROWS(NR), .COLS(NC),
      .IMPL(vrs_pkg::VRS_POINTER), .START_TAP(1'b0)) uut_ptr (
      .clk(clk), .rst_n(rst_n), .ra_row(ra_row), .ra_col(ra_col),
      .ra_wdata(ra_wdata), .ra_we(ra_we), .ra_xfer(ra_xfer),
      .ra_rdata(rd_b), .ser_step(ser_step), .ser_data(sd_b));

   typedef struct {
      logic [DW-1:0] rd, sa, sb;
      string         trd, tsa, tsb;
   } exp_t;

   exp_t q[$];
   int   n_cmp = 0;
   int   n_bad = 0;

   // Reference model
   logic [DW-1:0] mem_m [NR][NC];
   logic [DW-1:0] buf_a [NC];
   logic [DW-1:0] buf_b [NC];
   int            ptr_a = 0;
   int            ptr_b = 0;

   task automatic report;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   task automatic cmp(input string tag, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // Driver: drives at the falling edge, queues what the next rising edge produces.
   task automatic step(input bit we, input bit xf, input bit sh,
                       input int r, input int c, input logic [DW-1:0] wd,
                       input string trd, input string tsa, input string tsb);
      exp_t e;
      @(negedge clk);
      ra_we = we; ra_xfer = xf; ser_step = sh;
      ra_row = RW'(r); ra_col = CW'(c); ra_wdata = wd;
      e.rd = mem_m[r][c];
      if (xf) begin
         for (int k = 0; k < NC; k++) begin
            buf_a[k] = mem_m[r][k];
            buf_b[k] = mem_m[r][k];
         end
         ptr_a = c;
         ptr_b = 0;
      end else if (sh) begin
         ptr_a = (ptr_a + 1) % NC;
         ptr_b = (ptr_b + 1) % NC;
      end
      if (we) mem_m[r][c] = wd;
      e.sa = buf_a[ptr_a];
      e.sb = buf_b[ptr_b];
      e.trd = trd; e.tsa = tsa; e.tsb = tsb;
      q.push_back(e);
   endtask

   // Monitor: samples 5 ns after each rising edge.
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            if (e.trd != "") begin
               cmp(e.trd, "rdata rotate", rd_a, e.rd);
               cmp(e.trd, "rdata pointer", rd_b, e.rd);
            end
            if (e.tsa != "") cmp(e.tsa, "serial rotate/tap", sd_a, e.sa);
            if (e.tsb != "") cmp(e.tsb, "serial pointer/no-tap", sd_b, e.sb);
         end
      end
   end

   // Watchdog
   initial begin
      #(20 * 20000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      for (int r = 0; r < NR; r++)
         for (int c = 0; c < NC; c++) mem_m[r][c] = '0;
      for (int k = 0; k < NC; k++) begin buf_a[k] = '0; buf_b[k] = '0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: zero after reset, stepping does not change it
      repeat (3) step(0, 0, 1, 0, 0, '0, "", "R1", "R1");

      // Fill the array (no stepping)
      for (int r = 0; r < NR; r++)
         for (int c = 0; c < NC; c++)
            step(1, 0, 0, r, c, DW'(r * 37 + c * 5 + 1), "", "R1", "R1");

      // R2: plain reads
      for (int i = 0; i < 6; i++) step(0, 0, 0, i, i * 2 + 1, '0, "R2", "", "");
      // R2: write then read the same address
      step(1, 0, 0, 2, 3, 8'hAA, "", "", "");
      step(0, 0, 0, 2, 3, '0, "R2", "", "");
      // R3: read during write returns old word, next read the new one
      step(1, 0, 0, 5, 7, 8'h3C, "R3", "", "");
      step(0, 0, 0, 5, 7, '0, "R3", "", "");

      // R4 / R12: transfer row 3 starting at column 5
      step(0, 1, 0, 3, 5, '0, "", "R4", "R12");
      // R5: stepping through ascending columns
      for (int i = 0; i < 10; i++) step(0, 0, 1, 0, 0, '0, "", "R5", "R5");
      // R6: rotate/tap copy wraps from column 15 to 0
      step(0, 0, 1, 0, 0, '0, "", "R6", "R5");
      for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 0, '0, "", "R5", "R6");

      // R7 with R11: hold while reading
      for (int i = 0; i < 4; i++) step(0, 0, 0, i, i, '0, "R11", "R7", "R7");
      // R11: reads while stepping
      for (int i = 0; i < 4; i++) step(0, 0, 1, 7, i, '0, "R11", "R5", "R5");

      // R8: rewrite the captured row during a full lap
      for (int i = 0; i < NC; i++)
         step(1, 0, 1, 3, i, DW'(8'hF0 ^ i), "", "R8", "R8");
      for (int i = 0; i < 4; i++) step(0, 0, 1, 3, i, '0, "R2", "R8", "R8");

      // R9: transfer and step together
      step(0, 1, 1, 1, 9, '0, "", "R9", "R12");
      step(0, 0, 1, 0, 0, '0, "", "R5", "R5");

      // R10: transfer with a write to the same row
      step(1, 1, 0, 4, 2, 8'h99, "", "R10", "R10");
      step(0, 0, 0, 4, 2, '0, "R2", "R10", "R10");
      for (int i = 0; i < NC + 1; i++) step(0, 0, 1, 0, 0, '0, "", "R6", "R6");

      step(0, 0, 0, 0, 0, '0, "", "", "");
      repeat (2) @(negedge clk);
      report();
   end

endmodule